// File: doc/BRIEF.md
# CAN Test-Mode Register and Pin Router

This block holds the test-control register of a CAN controller and the routing between the protocol core and the two bus pins. Software reaches the register through a simple register port with an address, a write strobe, write data and combinational read data. A test-enable input comes from the controller's main control register. While it is low, the register cannot be written and every test function is off, so the pins carry normal traffic.

While test-enable is high, the register picks one of several pin arrangements. Internal loopback feeds the core its own transmit bit. Silent mode keeps the bus recessive but still listens to it. External loopback lets the core accept its own frame from the bus. A two-bit transmit field can override the transmit pin with the sample-point strobe, a forced dominant level or a forced recessive level. A RAM direct-access flag is exported to the message memory.

The receive pin passes through a synchronizer before it is used. All signals here are single control or pin bits, so there is no valid/ready stream and no back-pressure. Every port is a plain level.

Top module: `cantm_top`

## Requirements
- R1: After reset, all writable fields are zero. A read of the register then returns only the synchronized receive level in bit 7.
- R2: The register answers only at byte address 0x14. Its read layout is: bit 9 RAM direct access, bit 8 external loopback, bit 7 receive level, bits 6:5 transmit select, bit 4 internal loopback, bit 3 silent. Other addresses read zero and ignore writes.
- R3: Bits 31:10 and 2:0 always read zero, and data written to them is discarded.
- R4: A write changes the fields only while test_en is high. With test_en low, the fields keep their previous values.
- R5: While test_en is low, pin_tx equals core_tx and core_rx equals the synchronized pin_rx. ram_direct_en and self_ack_ok are both 0, whatever the fields hold.
- R6: The transmit select field sets pin_tx as follows: 00 passes the core level (see R8 and R9), 01 outputs core_sample, 10 outputs 0 (dominant), 11 outputs 1 (recessive). A nonzero select takes priority over the loopback and silent settings on the pin.
- R7: pin_rx reaches core_rx and read bit 7 through two flops. A level present at a clock edge appears after the second following edge. Both flops reset to 1 (recessive).
- R8: In internal loopback, core_rx equals core_tx and pin_rx is ignored. With select 00, pin_tx is 1. The external loopback bit then makes no difference to either pin path.
- R9: In silent mode without internal loopback, core_rx follows the synchronized pin_rx. With select 00, pin_tx is 1.
- R10: In external loopback without internal loopback or silent mode, pin_tx follows core_tx and core_rx follows the synchronized pin_rx. self_ack_ok is high whenever test_en and either loopback bit are set.
- R11: ram_direct_en is high exactly when test_en and the RAM direct-access field are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| test_en | input | 1 | Test enable from the main control register |
| core_tx | input | 1 | Transmit bit from the protocol core |
| core_sample | input | 1 | Sample-point strobe from bit timing |
| pin_rx | input | 1 | CAN receive pin, asynchronous |
| pin_tx | output | 1 | CAN transmit pin |
| core_rx | output | 1 | Receive bit presented to the core |
| ram_direct_en | output | 1 | RAM direct-access enable |
| self_ack_ok | output | 1 | Core may treat its own frame as acknowledged |

## Verification
pin_tx, ram_direct_en, self_ack_ok, core_rx in internal loopback, and read data settle in the same cycle as their inputs. A register write is visible after the next clock edge. Any path from pin_rx is due two edges later. The bench changes its inputs on a falling edge and waits three rising edges before sampling on the next falling edge, so every path has settled. A separate timing check samples pin_rx one edge and two edges after a change to pin down the synchronizer depth.

// File: rtl/cantm_pkg.sv
package cantm_pkg;
  localparam int DATA_W = 32;
  localparam int BIT_RDA    = 9;
  localparam int BIT_EXL    = 8;
  localparam int BIT_RXLVL  = 7;
  localparam int BIT_TXS_HI = 6;
  localparam int BIT_TXS_LO = 5;
  localparam int BIT_LBACK  = 4;
  localparam int BIT_SILENT = 3;
  localparam logic [DATA_W-1:0] USED_MASK = 32'h0000_03F8;

  typedef enum logic [1:0] {
    TXS_CORE   = 2'b00,
    TXS_SAMPLE = 2'b01,
    TXS_DOM    = 2'b10,
    TXS_REC    = 2'b11
  } txsel_e;

  typedef struct packed {
    logic   rda;
    logic   exl;
    txsel_e txsel;
    logic   lback;
    logic   silent;
  } tm_fields_t;
endpackage

// File: rtl/cantm_sync.sv
module cantm_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RESET_VAL;
        else if (g == 0) chain[g] <= d_async;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cantm_regs.sv
module cantm_regs
  import cantm_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              test_en,
  input  logic              rx_level,
  output tm_fields_t        fields,
  output logic [DATA_W-1:0] rdata
);
  logic hit;
  assign hit = (addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields <= '0;
    end else if (we && hit && test_en) begin
      fields.rda    <= wdata[BIT_RDA];
      fields.exl    <= wdata[BIT_EXL];
      fields.txsel  <= txsel_e'(wdata[BIT_TXS_HI:BIT_TXS_LO]);
      fields.lback  <= wdata[BIT_LBACK];
      fields.silent <= wdata[BIT_SILENT];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[BIT_RDA]               = fields.rda;
      rdata[BIT_EXL]               = fields.exl;
      rdata[BIT_RXLVL]             = rx_level;
      rdata[BIT_TXS_HI:BIT_TXS_LO] = fields.txsel;
      rdata[BIT_LBACK]             = fields.lback;
      rdata[BIT_SILENT]            = fields.silent;
    end
  end
endmodule

// File: rtl/cantm_router.sv
module cantm_router
  import cantm_pkg::*;
(
  input  logic       test_en,
  input  tm_fields_t fields,
  input  logic       core_tx,
  input  logic       core_sample,
  input  logic       rx_sync,
  output logic       pin_tx,
  output logic       core_rx,
  output logic       self_ack_ok,
  output logic       ram_direct_en
);
  tm_fields_t eff;
  logic       quiet;

  assign eff   = test_en ? fields : '0;
  assign quiet = eff.lback | eff.silent;

  always_comb begin
    core_rx = eff.lback ? core_tx : rx_sync;
    unique case (eff.txsel)
      TXS_SAMPLE: pin_tx = core_sample;
      TXS_DOM:    pin_tx = 1'b0;
      TXS_REC:    pin_tx = 1'b1;
      default:    pin_tx = quiet ? 1'b1 : core_tx;
    endcase
  end

  assign self_ack_ok   = eff.lback | eff.exl;
  assign ram_direct_en = eff.rda;
endmodule

// File: rtl/cantm_top.sv
module cantm_top
  import cantm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              test_en,
  input  logic              core_tx,
  input  logic              core_sample,
  input  logic              pin_rx,
  output logic              pin_tx,
  output logic              core_rx,
  output logic              ram_direct_en,
  output logic              self_ack_ok
);
  localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'h14);

  tm_fields_t fld_q;
  logic       rx_s;

  cantm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_rx), .q_sync(rx_s)
  );

  cantm_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .test_en(test_en), .rx_level(rx_s),
    .fields(fld_q), .rdata(bus_rdata)
  );

  cantm_router u_route (
    .test_en(test_en), .fields(fld_q), .core_tx(core_tx),
    .core_sample(core_sample), .rx_sync(rx_s), .pin_tx(pin_tx),
    .core_rx(core_rx), .self_ack_ok(self_ack_ok),
    .ram_direct_en(ram_direct_en)
  );
endmodule

// File: rtl/cantm_checker.sv
module cantm_checker
  import cantm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              test_en,
  input logic              bus_we,
  input logic              core_tx,
  input logic              pin_rx,
  input logic              pin_tx,
  input logic              core_rx,
  input logic              ram_direct_en,
  input logic              self_ack_ok,
  input logic [DATA_W-1:0] bus_rdata,
  input tm_fields_t        fld
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~USED_MASK) == '0);

  assert_write_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !test_en) |=> $stable(fld));

  assert_normal_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> (pin_tx == core_tx) && !ram_direct_en && !self_ack_ok);

  assert_sync_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !(test_en && fld.lback)) |-> core_rx == $past(pin_rx, 2));

  assert_int_loop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && fld.lback) |-> core_rx == core_tx);

  assert_silent_rec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && fld.silent && fld.txsel == TXS_CORE) |-> pin_tx);

  assert_rda_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ram_direct_en |-> (test_en && fld.rda));
endmodule

bind cantm_top cantm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .test_en(test_en), .bus_we(bus_we),
  .core_tx(core_tx), .pin_rx(pin_rx), .pin_tx(pin_tx), .core_rx(core_rx),
  .ram_direct_en(ram_direct_en), .self_ack_ok(self_ack_ok),
  .bus_rdata(bus_rdata), .fld(fld_q)
);

// File: tb/cantm_top_test.sv
module cantm_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h14;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        test_en = 1'b0, core_tx = 1'b1, core_sample = 1'b0, pin_rx = 1'b1;
  logic        pin_tx, core_rx, ram_direct_en, self_ack_ok;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  cantm_top uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .test_en(test_en),
    .core_tx(core_tx), .core_sample(core_sample), .pin_rx(pin_rx),
    .pin_tx(pin_tx), .core_rx(core_rx), .ram_direct_en(ram_direct_en),
    .self_ack_ok(self_ack_ok)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(logic [5:0] f);
    return (32'(f[5]) << 9) | (32'(f[4]) << 8) | (32'(f[3:2]) << 5) |
           (32'(f[1]) << 4) | (32'(f[0]) << 3);
  endfunction

  // {pin_tx, core_rx, ram_direct_en, self_ack_ok}
  function automatic logic [3:0] model(logic te, logic [5:0] f, logic ct,
                                       logic cs, logic rx);
    logic rda, exl, lb, sil, ptx, crx;
    logic [1:0] ts;
    rda = te & f[5]; exl = te & f[4]; ts = te ? f[3:2] : 2'b00;
    lb = te & f[1]; sil = te & f[0];
    crx = lb ? ct : rx;
    case (ts)
      2'b01:   ptx = cs;
      2'b10:   ptx = 1'b0;
      2'b11:   ptx = 1'b1;
      default: ptx = (lb | sil) ? 1'b1 : ct;
    endcase
    return {ptx, crx, rda, lb | exl};
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h14;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset readback", bus_rdata, 32'h80);
    chk("R1 reset pin_tx", {31'd0, pin_tx}, 32'd1);

    // R4: locked write with test_en low
    wr(8'h14, 32'hFFFF_FFFF);
    #1 chk("R4 locked write ignored", bus_rdata, 32'h80);

    // R2: other address ignores writes and reads zero
    test_en = 1'b1;
    wr(8'h10, 32'h0000_03F8);
    bus_addr = 8'h10; #1;
    chk("R2 other address reads zero", bus_rdata, 32'h0);
    bus_addr = 8'h14; #1;
    chk("R2 other address write ignored", bus_rdata, 32'h80);

    // Exhaustive sweep over all field settings
    for (int f = 0; f < 64; f++) begin
      test_en = 1'b1; pin_rx = 1'b1;
      wr(8'h14, enc(6'(f)) | 32'hFFFF_FC07); // R3 junk in reserved bits
      repeat (2) @(negedge clk); #1;
      chk("R2 R3 field readback", bus_rdata, enc(6'(f)) | 32'h80);
      test_en = 1'b0;
      wr(8'h14, ~enc(6'(f)));
      #1 chk("R4 locked write keeps fields", bus_rdata, enc(6'(f)) | 32'h80);
      for (int c = 0; c < 16; c++) begin
        logic [3:0] exp;
        @(negedge clk);
        test_en = c[3]; core_tx = c[2]; core_sample = c[1]; pin_rx = c[0];
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        exp = model(c[3], 6'(f), c[2], c[1], c[0]);
        chk("R5 R6 R8 R9 R10 pin_tx", {31'd0, pin_tx}, {31'd0, exp[3]});
        chk("R5 R7 R8 R9 R10 core_rx", {31'd0, core_rx}, {31'd0, exp[2]});
        chk("R11 ram_direct_en", {31'd0, ram_direct_en}, {31'd0, exp[1]});
        chk("R10 self_ack_ok", {31'd0, self_ack_ok}, {31'd0, exp[0]});
      end
    end

    // R7: synchronizer depth, and read bit 7 tracking
    test_en = 1'b1;
    wr(8'h14, 32'h0);
    @(negedge clk); pin_rx = 1'b0;
    @(posedge clk); @(negedge clk); #1;
    chk("R7 one edge still old", {31'd0, core_rx}, 32'd1);
    @(posedge clk); @(negedge clk); #1;
    chk("R7 two edges new level", {31'd0, core_rx}, 32'd0);
    chk("R7 read bit 7 dominant", bus_rdata, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule